// File: doc/BRIEF.md
# Hard-Sectored Rotation Timing Generator

This block produces the rotational timing that a hard-sectored disk drive shows to its controller, for use in logic that stands in for such a drive. A free-running position counter models one turn of the platter, measured in clock cycles. From that position the block drives two active-low strobes and a sector number.

The index strobe pulses once per turn. The sector strobe pulses at the start of every sector, and the first of those pulses lands exactly on the index pulse with the same width. The sector strobe is gated by the active-low drive-select input, so an unselected drive shows a quiet sector line while its index line keeps running.

A spin-enable input freezes the platter position and silences both strobes. A registered sector number tells neighbouring logic which sector is passing under the head. The turn length, pulse width and sector count are parameters. The sector pitch is the turn length divided by the sector count, and any remainder of that division is added to the last sector.

Top module: `hsect_timing_gen`

## Requirements
- R1: While spin_en is high, index_n falls exactly once every REV_CYCLES clock cycles.
- R2: Each index_n pulse stays low for exactly PULSE_CYCLES consecutive cycles.
- R3: While drv_sel_n is low, sector_n falls in the same cycle as index_n and stays low for the same number of cycles.
- R4: While selected, sector_n falls NUM_SECTORS times per turn. Sector k (k = 0 to NUM_SECTORS-1) falls k*(REV_CYCLES/NUM_SECTORS) cycles after index_n falls. The gap from the last sector to the next index is the pitch plus REV_CYCLES mod NUM_SECTORS.
- R5: Every sector_n pulse stays low for exactly PULSE_CYCLES cycles.
- R6: sector_n is high in any cycle whose preceding clock edge saw drv_sel_n high. drv_sel_n has no effect on index_n, and a sector pulse resumes on the next edge once drv_sel_n returns low.
- R7: cur_sector is an unsigned count from 0 to NUM_SECTORS-1. It takes the new sector number in the same cycle that the sector pulse for that sector begins, it reads 0 whenever index_n is low, and it wraps from NUM_SECTORS-1 to 0 at index.
- R8: While spin_en is low, the platter position and cur_sector hold, and both strobes are high from the next cycle on. When spin_en returns high, rotation resumes from the held position, so the next index is delayed by exactly the number of held cycles.
- R9: While rst is high, index_n and sector_n are high and cur_sector is 0. At the first clock edge after rst falls with spin_en high, the index pulse (and the sector pulse, if the drive is selected) begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| drv_sel_n | input | 1 | Drive select, active low; gates the sector strobe |
| spin_en | input | 1 | High lets the platter turn; low freezes it |
| index_n | output | 1 | Once-per-turn index strobe, active low |
| sector_n | output | 1 | Sector boundary strobe, active low |
| cur_sector | output | $clog2(NUM_SECTORS) | Number of the sector currently under the head |

## Verification
A full turn is observed with the drive selected. This pins down the index period, both pulse widths, the spacing of every sector pulse and the longer final gap that comes from the remainder, and it confirms that the sector number steps in step with each pulse. A turn with the drive deselected separates the gated sector line from the free-running index line. A select toggle inside the index pulse shows the one-edge gating latency in both directions. A hold in the middle of a turn, followed by a measurement of the delay to the next index, tells a true freeze of the position apart from a counter that keeps running or restarts.

// File: rtl/hsect_pkg.sv
package hsect_pkg;

    // Registered strobe pair, both active low.
    typedef struct packed {
        logic idx_n;
        logic sec_n;
    } strobes_t;

    // Position decode flags derived from the platter counter.
    typedef struct packed {
        logic at_index;
        logic in_pulse;
    } phase_flags_t;

    // Regular sector pitch in cycles.
    function automatic int sector_pitch(input int rev_cycles, input int n_sectors);
        return rev_cycles / n_sectors;
    endfunction

    // Final sector absorbs the remainder so a turn lasts rev_cycles exactly.
    function automatic int final_sector_len(input int rev_cycles, input int n_sectors);
        return (rev_cycles / n_sectors) + (rev_cycles % n_sectors);
    endfunction

endpackage

// File: rtl/hsect_platter_ctr.sv
module hsect_platter_ctr #(
    parameter int REV_CYCLES  = 1710,
    parameter int NUM_SECTORS = 17,
    parameter int SEC_W       = $clog2(NUM_SECTORS),
    parameter int SLOT_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              advance,
    output logic [SEC_W-1:0]  sec,
    output logic [SLOT_W-1:0] slot
);
    import hsect_pkg::*;

    localparam int PITCH     = sector_pitch(REV_CYCLES, NUM_SECTORS);
    localparam int FINAL_LEN = final_sector_len(REV_CYCLES, NUM_SECTORS);

    localparam logic [SEC_W-1:0]  SEC_LAST   = SEC_W'(NUM_SECTORS - 1);
    localparam logic [SLOT_W-1:0] SLOT_END   = SLOT_W'(PITCH - 1);
    localparam logic [SLOT_W-1:0] SLOT_FINAL = SLOT_W'(FINAL_LEN - 1);

    logic [SLOT_W-1:0] slot_limit;
    logic              sec_done;

    always_comb begin
        slot_limit = (sec == SEC_LAST) ? SLOT_FINAL : SLOT_END;
        sec_done   = (slot == slot_limit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sec  <= '0;
            slot <= '0;
        end else if (advance) begin
            if (sec_done) begin
                slot <= '0;
                sec  <= (sec == SEC_LAST) ? '0 : sec + 1'b1;
            end else begin
                slot <= slot + 1'b1;
            end
        end
    end

    // R7: the sector number never leaves its legal range
    a_r7_sector_range: assert property (@(posedge clk) disable iff (rst)
        sec <= SEC_LAST);

    // R8: a held platter keeps its position
    a_r8_position_frozen: assert property (@(posedge clk) disable iff (rst)
        !advance |=> ($stable(sec) && $stable(slot)));

    // R4: a new sector always begins at the first slot
    a_r4_sector_starts_at_slot0: assert property (@(posedge clk) disable iff (rst)
        !$stable(sec) |-> (slot == '0));

endmodule

// File: rtl/hsect_strobe_gen.sv
module hsect_strobe_gen #(
    parameter int PULSE_CYCLES = 8,
    parameter int SEC_W        = 5,
    parameter int SLOT_W       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spin_en,
    input  logic              drv_sel_n,
    input  logic [SEC_W-1:0]  sec,
    input  logic [SLOT_W-1:0] slot,
    output hsect_pkg::strobes_t strobes,
    output logic [SEC_W-1:0]  cur_sector
);
    import hsect_pkg::*;

    localparam logic [SLOT_W-1:0] PULSE_LEN = SLOT_W'(PULSE_CYCLES);

    phase_flags_t flags;

    always_comb begin
        flags.at_index = (sec == '0);
        flags.in_pulse = (slot < PULSE_LEN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strobes.idx_n <= 1'b1;
            strobes.sec_n <= 1'b1;
            cur_sector    <= '0;
        end else begin
            strobes.idx_n <= !(spin_en && flags.at_index && flags.in_pulse);
            strobes.sec_n <= !(spin_en && flags.in_pulse && !drv_sel_n);
            if (spin_en) begin
                cur_sector <= sec;
            end
        end
    end

    // R3: a selected drive shows the sector strobe together with index
    a_r3_index_carries_sector: assert property (@(posedge clk) disable iff (rst)
        (!strobes.idx_n && !$past(drv_sel_n)) |-> !strobes.sec_n);

    // R6: deselection silences the sector strobe on the next edge
    a_r6_sector_gated: assert property (@(posedge clk) disable iff (rst)
        $past(drv_sel_n) |-> strobes.sec_n);

    // R8: no strobe while the platter is stopped
    a_r8_quiet_when_stopped: assert property (@(posedge clk) disable iff (rst)
        !$past(spin_en) |-> (strobes.idx_n && strobes.sec_n));

    // R7: index is only ever seen in sector zero
    a_r7_index_in_sector0: assert property (@(posedge clk) disable iff (rst)
        !strobes.idx_n |-> (cur_sector == '0));

endmodule

// File: rtl/hsect_timing_gen.sv
module hsect_timing_gen #(
    parameter int REV_CYCLES   = 1710,
    parameter int NUM_SECTORS  = 17,
    parameter int PULSE_CYCLES = 8,
    parameter int SEC_W        = $clog2(NUM_SECTORS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             drv_sel_n,
    input  logic             spin_en,
    output logic             index_n,
    output logic             sector_n,
    output logic [SEC_W-1:0] cur_sector
);
    import hsect_pkg::*;

    localparam int FINAL_LEN = final_sector_len(REV_CYCLES, NUM_SECTORS);
    localparam int SLOT_W    = $clog2(FINAL_LEN + 1);

    logic [SEC_W-1:0]  pos_sec;
    logic [SLOT_W-1:0] pos_slot;
    strobes_t          strobes;

    hsect_platter_ctr #(
        .REV_CYCLES  (REV_CYCLES),
        .NUM_SECTORS (NUM_SECTORS),
        .SEC_W       (SEC_W),
        .SLOT_W      (SLOT_W)
    ) u_platter (
        .clk     (clk),
        .rst     (rst),
        .advance (spin_en),
        .sec     (pos_sec),
        .slot    (pos_slot)
    );

    hsect_strobe_gen #(
        .PULSE_CYCLES (PULSE_CYCLES),
        .SEC_W        (SEC_W),
        .SLOT_W       (SLOT_W)
    ) u_strobes (
        .clk        (clk),
        .rst        (rst),
        .spin_en    (spin_en),
        .drv_sel_n  (drv_sel_n),
        .sec        (pos_sec),
        .slot       (pos_slot),
        .strobes    (strobes),
        .cur_sector (cur_sector)
    );

    assign index_n  = strobes.idx_n;
    assign sector_n = strobes.sec_n;

endmodule

// File: tb/test_hsect_timing_gen.sv
module test_hsect_timing_gen;

    localparam int REV   = 1710;
    localparam int NSEC  = 17;
    localparam int PW    = 8;
    localparam int SW    = $clog2(NSEC);
    localparam int PITCH = REV / NSEC;
    localparam int REM   = REV % NSEC;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          drv_sel_n = 1'b0;
    logic          spin_en = 1'b1;
    logic          index_n;
    logic          sector_n;
    logic [SW-1:0] cur_sector;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    hsect_timing_gen #(
        .REV_CYCLES   (REV),
        .NUM_SECTORS  (NSEC),
        .PULSE_CYCLES (PW)
    ) i_hsect_timing_gen (
        .clk        (clk),
        .rst        (rst),
        .drv_sel_n  (drv_sel_n),
        .spin_en    (spin_en),
        .index_n    (index_n),
        .sector_n   (sector_n),
        .cur_sector (cur_sector)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Returns at the negedge where index_n has just fallen.
    task automatic wait_idx_fall(output int waited);
        logic prev;
        prev   = index_n;
        waited = 0;
        while (waited < 4 * REV) begin
            @(negedge clk);
            waited++;
            if (prev && !index_n) return;
            prev = index_n;
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check(index_n === 1'b1, "R9 index_n in reset", int'(index_n), 1);
        check(sector_n === 1'b1, "R9 sector_n in reset", int'(sector_n), 1);
        check(cur_sector === '0, "R9 cur_sector in reset", int'(cur_sector), 0);
        rst = 1'b0;
        @(negedge clk);
        check(index_n === 1'b0, "R9 index starts after reset", int'(index_n), 0);
        check(sector_n === 1'b0, "R3 sector starts with index after reset", int'(sector_n), 0);
    endtask

    task automatic t_revolution;
        int w, sfalls, ifalls, idx_low, sec_low, bad_pos, bad_cur, last_fall;
        logic pi, ps;
        wait_idx_fall(w);
        pi = 1'b1; ps = 1'b1;
        sfalls = 0; ifalls = 0; idx_low = 0; sec_low = 0;
        bad_pos = 0; bad_cur = 0; last_fall = 0;
        for (int t = 0; t < REV; t++) begin
            if (t > 0) @(negedge clk);
            if (pi && !index_n) ifalls++;
            if (ps && !sector_n) begin
                if (t != sfalls * PITCH) bad_pos++;
                if (int'(cur_sector) != sfalls) bad_cur++;
                if (t == 0 && index_n !== 1'b0) bad_pos++;
                last_fall = t;
                sfalls++;
            end
            if (!index_n) idx_low++;
            if (!sector_n) sec_low++;
            pi = index_n; ps = sector_n;
        end
        check(ifalls == 1, "R1 one index per turn", ifalls, 1);
        check(idx_low == PW, "R2 index width", idx_low, PW);
        check(sfalls == NSEC, "R4 sector pulses per turn", sfalls, NSEC);
        check(bad_pos == 0, "R4 sector spacing and index alignment", bad_pos, 0);
        check(sec_low == NSEC * PW, "R5 sector pulse widths", sec_low, NSEC * PW);
        check(bad_cur == 0, "R7 cur_sector at each pulse", bad_cur, 0);
        @(negedge clk);
        check(pi && !index_n, "R1 next index after REV cycles", int'(index_n), 0);
        check(ps && !sector_n, "R4 final gap pitch plus remainder",
              REV - last_fall, PITCH + REM);
        check(cur_sector === '0, "R7 cur_sector wraps to 0", int'(cur_sector), 0);
        check(!sector_n, "R3 sector with index same cycle", int'(sector_n), 0);
    endtask

    task automatic t_deselect;
        int w, sec_low, ifalls;
        logic pi;
        drv_sel_n = 1'b1;
        wait_idx_fall(w);
        sec_low = 0; ifalls = 1; pi = 1'b0;
        if (!sector_n) sec_low++;
        for (int t = 1; t < REV; t++) begin
            @(negedge clk);
            if (!sector_n) sec_low++;
            if (pi && !index_n) ifalls++;
            pi = index_n;
        end
        check(sec_low == 0, "R6 no sector pulse when deselected", sec_low, 0);
        check(ifalls == 1 && w <= 2 * REV, "R6 index unaffected by deselect", ifalls, 1);
        drv_sel_n = 1'b0;
    endtask

    task automatic t_gate_latency;
        int w;
        wait_idx_fall(w);
        drv_sel_n = 1'b1;
        @(negedge clk);
        check(sector_n === 1'b1, "R6 sector released one edge after deselect", int'(sector_n), 1);
        check(index_n === 1'b0, "R6 index still low while deselected", int'(index_n), 0);
        drv_sel_n = 1'b0;
        @(negedge clk);
        check(sector_n === 1'b0, "R6 sector resumes on reselect", int'(sector_n), 0);
    endtask

    task automatic t_hold;
        int w, bad, n;
        logic [SW-1:0] held;
        wait_idx_fall(w);
        repeat (300) @(negedge clk);
        held = cur_sector;
        check(int'(held) == 300 / PITCH, "R7 cur_sector mid-turn", int'(held), 300 / PITCH);
        spin_en = 1'b0;
        bad = 0;
        for (int h = 0; h < 50; h++) begin
            @(negedge clk);
            if (index_n !== 1'b1 || sector_n !== 1'b1) bad++;
            if (cur_sector !== held) bad++;
        end
        check(bad == 0, "R8 strobes high and sector held while stopped", bad, 0);
        spin_en = 1'b1;
        wait_idx_fall(n);
        check(n == REV - 300, "R8 rotation resumes from held position", n, REV - 300);
    endtask

    initial begin
        t_reset();
        t_revolution();
        t_deselect();
        t_revolution();
        t_gate_latency();
        t_hold();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule